// File: doc/BRIEF.md
# Single-Slot Blocking Mailbox

This block holds one message at a time and passes it from a group of producer ports to a group of consumer ports. A producer raises its request with its data, and a consumer raises its request to ask for a message. A send is taken only into an empty slot, so a stored message is never overwritten. A receive is served only from a full slot. When several producers, or several consumers, wait at the same time, the lowest-numbered port is served first. A waiting port stays waiting for as long as it needs, because a request has no timeout.

Each port uses a request/grant handshake. A port holds its request high until it sees its grant. The grant is a one-cycle pulse. The port drops its request in the cycle in which the grant is visible. Received data appears on the shared output in the same cycle as the receive grant. The data width and the number of ports on each side are parameters.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset the slot is empty, every send and receive grant is low, and `rcv_data` is zero.
- R2: A send is granted only when the slot is empty. While the slot is full, no `snd_gnt` bit rises. The stored message keeps its value until it is received.
- R3: When several producers request together at an accepting edge, the grant goes to the lowest-indexed requesting port. Port 0 has the highest priority.
- R4: A receive is granted only when the slot is full. While the slot is empty, no `rcv_gnt` bit rises.
- R5: When several consumers request together at a serving edge, the grant goes to the lowest-indexed requesting port.
- R6: In the cycle where a `rcv_gnt` bit is high, `rcv_data` equals the data of the most recently granted send.
- R7: Both grants are registered. A request seen at the edge that serves it gives a grant in the following cycle. A message granted to a producer in cycle t can be granted to a consumer in cycle t+1 at the earliest. A send grant and a receive grant are never high in the same cycle.
- R8: Each grant vector is zero or one-hot, and each grant lasts exactly one cycle.
- R9: A producer that keeps waiting while the slot is full is granted at the first accepting edge after the slot empties. It loses no request on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| snd_req | input | N_TX | Per-producer send request, held until granted |
| snd_data | input | N_TX*W | Producer data; port i uses bits [i*W +: W] |
| snd_gnt | output | N_TX | One-cycle send grant to the selected producer |
| rcv_req | input | N_RX | Per-consumer receive request, held until granted |
| rcv_gnt | output | N_RX | One-cycle receive grant to the selected consumer |
| rcv_data | output | W | Message delivered together with the receive grant |

## Verification
A request placed before a rising edge that can serve it gives its grant in the cycle right after that edge. That is one register from request to grant. Received data comes from the same register stage as the receive grant. A message accepted at one edge can leave the slot no earlier than the next edge. The bench drives inputs on the falling edge and samples on the falling edge that follows each rising edge, which is exactly where each grant is due. Blocking cases run a request for several cycles and check the grant is zero at every falling edge. The case of a waiting producer is followed edge by edge: one edge to read the slot, then one edge to accept the new send.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam int unsigned DEF_W     = 8;
    localparam int unsigned DEF_PORTS = 3;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mbx_prio_pick.sv
module mbx_prio_pick #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh,
    output logic         any
);
    // isolate lowest set bit: index 0 wins
    assign oh  = req & (~req + N'(1));
    assign any = |req;
endmodule

// File: rtl/mbx_data_sel.sv
module mbx_data_sel #(
    parameter int unsigned N = 2,
    parameter int unsigned W = 8
) (
    input  logic [N*W-1:0] data_flat,
    input  logic [N-1:0]   sel_oh,
    output logic [W-1:0]   data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < N; i++) begin
            data = data | (data_flat[i*W +: W] & {W{sel_oh[i]}});
        end
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [W-1:0] wr_data,
    input  logic        rd_en,
    output slot_state_e state,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_EMPTY;
            data  <= '0;
        end else if (wr_en && state == SLOT_EMPTY) begin
            state <= SLOT_FULL;
            data  <= wr_data;
        end else if (rd_en && state == SLOT_FULL) begin
            state <= SLOT_EMPTY;
        end
    end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned N_TX = DEF_PORTS,
    parameter int unsigned N_RX = DEF_PORTS,
    parameter int unsigned W    = DEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TX-1:0]   snd_req,
    input  logic [N_TX*W-1:0] snd_data,
    output logic [N_TX-1:0]   snd_gnt,
    input  logic [N_RX-1:0]   rcv_req,
    output logic [N_RX-1:0]   rcv_gnt,
    output logic [W-1:0]      rcv_data
);
    slot_state_e       slot_state;
    logic              slot_full;
    logic [W-1:0]      slot_data;
    logic [N_TX-1:0]   tx_oh;
    logic              tx_any;
    logic [N_RX-1:0]   rx_oh;
    logic              rx_any;
    logic [W-1:0]      tx_data;
    logic              do_write;
    logic              do_read;

    assign slot_full = (slot_state == SLOT_FULL);
    assign do_write  = tx_any && !slot_full;
    assign do_read   = rx_any && slot_full;

    mbx_prio_pick #(.N(N_TX)) u_tx_pick (.req(snd_req), .oh(tx_oh), .any(tx_any));
    mbx_prio_pick #(.N(N_RX)) u_rx_pick (.req(rcv_req), .oh(rx_oh), .any(rx_any));

    mbx_data_sel #(.N(N_TX), .W(W)) u_tx_sel (
        .data_flat(snd_data), .sel_oh(tx_oh), .data(tx_data)
    );

    mbx_slot #(.W(W)) u_slot (
        .clk(clk), .rst(rst),
        .wr_en(do_write), .wr_data(tx_data),
        .rd_en(do_read),
        .state(slot_state), .data(slot_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snd_gnt  <= '0;
            rcv_gnt  <= '0;
            rcv_data <= '0;
        end else begin
            snd_gnt <= do_write ? tx_oh : '0;
            rcv_gnt <= do_read  ? rx_oh : '0;
            if (do_read) rcv_data <= slot_data;
        end
    end
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
    parameter int unsigned N_TX = 2,
    parameter int unsigned N_RX = 2,
    parameter int unsigned W    = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [N_TX-1:0] snd_req,
    input logic [N_TX-1:0] snd_gnt,
    input logic [N_RX-1:0] rcv_req,
    input logic [N_RX-1:0] rcv_gnt,
    input logic [W-1:0]    rcv_data,
    input logic            slot_full,
    input logic [W-1:0]    slot_data
);
    p_snd_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (|snd_gnt) |-> (!$past(slot_full) && slot_full));

    p_hold_while_full_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(slot_full) && slot_full && !(|rcv_gnt)) |-> $stable(slot_data));

    p_snd_prio_r3: assert property (@(posedge clk) disable iff (rst)
        (|snd_gnt) |-> (((snd_gnt & ~$past(snd_req)) == '0) &&
                        (($past(snd_req) & (snd_gnt - N_TX'(1))) == '0)));

    p_rcv_when_full_r4: assert property (@(posedge clk) disable iff (rst)
        (|rcv_gnt) |-> ($past(slot_full) && !slot_full));

    p_rcv_prio_r5: assert property (@(posedge clk) disable iff (rst)
        (|rcv_gnt) |-> (((rcv_gnt & ~$past(rcv_req)) == '0) &&
                        (($past(rcv_req) & (rcv_gnt - N_RX'(1))) == '0)));

    p_rcv_data_r6: assert property (@(posedge clk) disable iff (rst)
        (|rcv_gnt) |-> (rcv_data == $past(slot_data)));

    p_no_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        !((|snd_gnt) && (|rcv_gnt)));

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(snd_gnt) && $onehot0(rcv_gnt));

    p_snd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (|snd_gnt) |=> !(|snd_gnt));

    p_rcv_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (|rcv_gnt) |=> !(|rcv_gnt));
endmodule

bind mbx_mailbox mbx_mailbox_chk #(.N_TX(N_TX), .N_RX(N_RX), .W(W)) i_chk (
    .clk(clk), .rst(rst),
    .snd_req(snd_req), .snd_gnt(snd_gnt),
    .rcv_req(rcv_req), .rcv_gnt(rcv_gnt), .rcv_data(rcv_data),
    .slot_full(slot_full), .slot_data(slot_data)
);

// File: tb/test_mbx_mailbox.sv
module test_mbx_mailbox;
    localparam int unsigned NT = 3;
    localparam int unsigned NR = 3;
    localparam int unsigned W  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NT-1:0]   snd_req = '0;
    logic [NT*W-1:0] snd_data = '0;
    logic [NT-1:0]   snd_gnt;
    logic [NR-1:0]   rcv_req = '0;
    logic [NR-1:0]   rcv_gnt;
    logic [W-1:0]    rcv_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbx_mailbox #(.N_TX(NT), .N_RX(NR), .W(W)) i_mbx_mailbox (
        .clk(clk), .rst(rst),
        .snd_req(snd_req), .snd_data(snd_data), .snd_gnt(snd_gnt),
        .rcv_req(rcv_req), .rcv_gnt(rcv_gnt), .rcv_data(rcv_data)
    );

    // {send mask, receive mask, data base, expected sender, expected receiver}
    localparam int VN = 6;
    localparam logic [17:0] VEC [VN] = '{
        {3'b001, 3'b001, 8'h10, 2'd0, 2'd0},
        {3'b110, 3'b100, 8'h20, 2'd1, 2'd2},
        {3'b111, 3'b011, 8'h30, 2'd0, 2'd0},
        {3'b100, 3'b110, 8'h40, 2'd2, 2'd1},
        {3'b101, 3'b111, 8'hA0, 2'd0, 2'd0},
        {3'b010, 3'b010, 8'h5C, 2'd1, 2'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] base);
        for (int i = 0; i < NT; i++) snd_data[i*W +: W] = base + W'(i);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        // R1: reset state
        chk("R1 snd_gnt", 32'(snd_gnt), 0);
        chk("R1 rcv_gnt", 32'(rcv_gnt), 0);
        chk("R1 rcv_data", 32'(rcv_data), 0);

        // vector table: R3 R5 R6 R7
        for (int v = 0; v < VN; v++) begin
            logic [2:0] sm, rm;
            logic [7:0] base;
            logic [1:0] es, er;
            {sm, rm, base, es, er} = VEC[v];
            load(base);
            snd_req = sm;
            cyc();
            chk("R3 send priority", 32'(snd_gnt), 32'(3'b001 << es));
            chk("R7 no receive with send", 32'(rcv_gnt), 0);
            snd_req = '0;
            rcv_req = rm;
            cyc();
            chk("R5 receive priority", 32'(rcv_gnt), 32'(3'b001 << er));
            chk("R6 data", 32'(rcv_data), 32'(base + 8'(es)));
            chk("R8 send pulse", 32'(snd_gnt), 0);
            rcv_req = '0;
            cyc();
            chk("R8 receive pulse", 32'(rcv_gnt), 0);
        end

        // R4: receive on empty slot waits
        rcv_req = 3'b111;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R4 no grant while empty", 32'(rcv_gnt), 0);
        end
        rcv_req = '0;

        // R2 + R9: second producer waits while full, then is served
        snd_data = '0;
        snd_data[2*W +: W] = 8'h77;
        snd_req = 3'b100;
        cyc();
        chk("R2 first send", 32'(snd_gnt), 32'(3'b100));
        snd_req = 3'b001;
        snd_data[0 +: W] = 8'h11;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R2 blocked while full", 32'(snd_gnt), 0);
        end
        rcv_req = 3'b010;
        cyc();
        chk("R2 kept message", 32'(rcv_data), 32'h77);
        chk("R2 receiver", 32'(rcv_gnt), 32'(3'b010));
        chk("R9 not yet", 32'(snd_gnt), 0);
        rcv_req = '0;
        cyc();
        chk("R9 waiting sender served", 32'(snd_gnt), 32'(3'b001));
        snd_req = '0;
        rcv_req = 3'b100;
        cyc();
        chk("R6 waiting data", 32'(rcv_data), 32'h11);
        rcv_req = '0;
        cyc();

        // R7: earliest receive, send and receive requested together
        snd_data[1*W +: W] = 8'h3C;
        snd_req = 3'b010;
        rcv_req = 3'b001;
        cyc();
        chk("R7 send first", 32'(snd_gnt), 32'(3'b010));
        chk("R7 receive not same cycle", 32'(rcv_gnt), 0);
        snd_req = '0;
        cyc();
        chk("R7 receive next cycle", 32'(rcv_gnt), 32'(3'b001));
        chk("R7 data", 32'(rcv_data), 32'h3C);
        rcv_req = '0;
        cyc();
        chk("R8 pulse ends", 32'(rcv_gnt), 0);

        // R1: reset mid-stream clears full slot
        snd_req = 3'b001;
        cyc();
        snd_req = '0;
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        rcv_req = 3'b001;
        cyc();
        chk("R1 slot empty after reset", 32'(rcv_gnt), 0);
        rcv_req = '0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule